// File: doc/BRIEF.md
# Two-Wire Quad Potentiometer Command Engine

This block is the command layer of a slave device that controls four digital potentiometers over a two-wire serial bus. It sits behind a byte-level bus receiver. The receiver reports start and stop conditions, delivers each byte that the master writes, and takes back an acknowledge decision for every byte. For read transfers it takes a byte to shift out, and it reports the master's acknowledge on that byte.

A transfer has four parts: a device address byte, an instruction byte, exactly one data byte and a stop. The address byte is a fixed upper nibble (0101) followed by the four strap pins. The instruction byte holds an opcode, a two-bit slot field and a two-bit potentiometer field. The block keeps a tap-select register for each potentiometer and drives it straight onto that potentiometer's tap output. It also keeps a 16-byte image of the stored settings. A write to a stored slot updates the image and sends a one-cycle request to the nonvolatile store controller.

Top module: `dpc_cmd_engine`

## Requirements
- R1: An address byte equal to {4'b0101, addr_pins} is acknowledged: ack_vld and ack_ok are high in the cycle after rx_vld. Each acknowledged byte (address, instruction or data) gets its ack_vld pulse exactly one cycle after its rx_vld.
- R2: An address byte that does not match gets ack_vld with ack_ok low. The block then ignores all bytes, with no ack_vld, until the next start, and no register changes.
- R3: Instruction bits [7:4] are the opcode, bits [3:2] the slot and bits [1:0] the potentiometer. The valid opcodes are 1001 (read tap), 1010 (write tap), 1011 (read slot) and 1100 (write slot). The tap opcodes are valid only with slot bits 00. Any other instruction gets ack_ok low, the rest of the transfer is ignored, and nothing changes.
- R4: For a write-tap command, the data byte is acknowledged, and the tap output of the selected potentiometer (wiper_o[8p+7:8p]) takes the data one cycle after the stop.
- R5: For a read-tap command, tx_vld is high from the cycle after the instruction byte, and tx_data equals the selected tap register.
- R6: For a write-slot command, the slot image is updated. nv_req pulses for one cycle, one cycle after the stop, carrying nv_pot, nv_slot and nv_data. No tap output changes.
- R7: For a read-slot command, tx_data equals the stored image byte for the selected potentiometer and slot.
- R8: On a read, tx_vld drops in the cycle after the master's acknowledge report (mack_vld), whether that report is NACK or ACK.
- R9: A start that arrives in place of the final stop cancels the pending write. No register changes and nv_req stays low.
- R10: After reset every tap output equals WIPER_RST (8'h80 by default), the slot image is zero, and tx_vld, nv_req and ack_vld are low.
- R11: A second data byte in a write transfer gets ack_ok low, and the write is dropped.
- R12: A stop that arrives before the data byte leaves all registers unchanged and raises no nv_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_pins | input | 4 | Strap pins forming the low address nibble |
| evt_start | input | 1 | Start or repeated-start condition seen (one-cycle pulse) |
| evt_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| rx_vld | input | 1 | A byte written by the master is available |
| rx_data | input | 8 | Byte written by the master |
| ack_vld | output | 1 | Acknowledge decision valid for the last byte |
| ack_ok | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| tx_vld | output | 1 | Read data is being offered to the receiver |
| tx_data | output | 8 | Read data byte |
| mack_vld | input | 1 | Master acknowledge on the read byte has been sampled |
| mack_nack | input | 1 | 1 = master sent NACK |
| wiper_o | output | NPOT*8 | Tap-select outputs, 8 bits per potentiometer |
| nv_req | output | 1 | Request to program a stored slot (one-cycle pulse) |
| nv_pot | output | 2 | Potentiometer of the request |
| nv_slot | output | 2 | Slot of the request |
| nv_data | output | 8 | Data of the request |

## Verification
The bench targets the edges of the transfer framing. A repeated start in place of the stop would, on a faulty design, commit the write anyway. A second data byte would either be acknowledged or leave the earlier value to be committed. A stop straight after the instruction byte would write stale data. It also sends tap opcodes with nonzero slot bits and a wrong device address, which a loose decoder would accept and so alter a tap. Finally, it checks that a slot write raises the store request with the right potentiometer and slot but leaves every tap output alone. A design that mixed up the two register banks would move a tap or read back the wrong byte.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   localparam int BYTE_W = 8;

   localparam logic [3:0] OP_RD_TAP  = 4'b1001;
   localparam logic [3:0] OP_WR_TAP  = 4'b1010;
   localparam logic [3:0] OP_RD_SLOT = 4'b1011;
   localparam logic [3:0] OP_WR_SLOT = 4'b1100;

   typedef enum logic [2:0] {
      S_IDLE, S_ADDR, S_INSTR, S_WDATA, S_WSTOP, S_RDATA, S_RSTOP
   } st_t;

   typedef enum logic [2:0] {
      K_BAD, K_RD_TAP, K_WR_TAP, K_RD_SLOT, K_WR_SLOT
   } kind_t;

   typedef struct packed {
      kind_t      kind;
      logic [1:0] pot;
      logic [1:0] slot;
   } instr_t;
endpackage

// File: rtl/dpc_decode.sv
module dpc_decode
   import dpc_pkg::*;
#(
   parameter int NPOT  = 4,
   parameter int NSLOT = 4
) (
   input  logic [BYTE_W-1:0] ins,
   output instr_t            dec
);
   logic [3:0] op;
   logic       pot_ok;
   logic       slot_ok;

   assign op      = ins[7:4];
   assign pot_ok  = int'(ins[1:0]) < NPOT;
   assign slot_ok = int'(ins[3:2]) < NSLOT;

   always_comb begin
      dec.pot  = ins[1:0];
      dec.slot = ins[3:2];
      dec.kind = K_BAD;
      if (pot_ok) begin
         unique case (op)
            OP_RD_TAP:  if (ins[3:2] == 2'b00) dec.kind = K_RD_TAP;
            OP_WR_TAP:  if (ins[3:2] == 2'b00) dec.kind = K_WR_TAP;
            OP_RD_SLOT: if (slot_ok) dec.kind = K_RD_SLOT;
            OP_WR_SLOT: if (slot_ok) dec.kind = K_WR_SLOT;
            default:    dec.kind = K_BAD;
         endcase
      end
   end
endmodule

// File: rtl/dpc_regs.sv
module dpc_regs
   import dpc_pkg::*;
#(
   parameter int                NPOT      = 4,
   parameter int                NSLOT     = 4,
   parameter logic [BYTE_W-1:0] WIPER_RST = 8'h80
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_tap,
   input  logic                     wr_slot,
   input  logic [1:0]               sel_pot,
   input  logic [1:0]               sel_slot,
   input  logic [BYTE_W-1:0]        wdata,
   input  logic                     rd_slot,
   output logic [BYTE_W-1:0]        rdata,
   output logic [NPOT*BYTE_W-1:0]   tap_flat
);
   logic [BYTE_W-1:0] tap [NPOT];
   logic [BYTE_W-1:0] img [NPOT][NSLOT];

   for (genvar p = 0; p < NPOT; p++) begin : g_pot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             tap[p] <= WIPER_RST;
         else if (wr_tap && sel_pot == 2'(p))    tap[p] <= wdata;
      end
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) img[p][s] <= '0;
            else if (wr_slot && sel_pot == 2'(p) && sel_slot == 2'(s))
               img[p][s] <= wdata;
         end
      end
      assign tap_flat[p*BYTE_W +: BYTE_W] = tap[p];
   end

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NPOT; p++) begin
         if (sel_pot == 2'(p)) begin
            if (!rd_slot) rdata = tap[p];
            else begin
               for (int s = 0; s < NSLOT; s++)
                  if (sel_slot == 2'(s)) rdata = img[p][s];
            end
         end
      end
   end
endmodule

// File: rtl/dpc_cmd_engine.sv
module dpc_cmd_engine
   import dpc_pkg::*;
#(
   parameter int                NPOT      = 4,
   parameter int                NSLOT     = 4,
   parameter logic [3:0]        ID_NIBBLE = 4'b0101,
   parameter logic [BYTE_W-1:0] WIPER_RST = 8'h80
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [3:0]             addr_pins,
   input  logic                   evt_start,
   input  logic                   evt_stop,
   input  logic                   rx_vld,
   input  logic [7:0]             rx_data,
   output logic                   ack_vld,
   output logic                   ack_ok,
   output logic                   tx_vld,
   output logic [7:0]             tx_data,
   input  logic                   mack_vld,
   input  logic                   mack_nack,
   output logic [NPOT*8-1:0]      wiper_o,
   output logic                   nv_req,
   output logic [1:0]             nv_pot,
   output logic [1:0]             nv_slot,
   output logic [7:0]             nv_data
);
   if (NPOT < 1 || NPOT > 4)   begin : g_bad_npot  $error("NPOT must be 1..4");  end
   if (NSLOT < 1 || NSLOT > 4) begin : g_bad_nslot $error("NSLOT must be 1..4"); end

   localparam logic [7:0] DEV_ADDR_HI = {ID_NIBBLE, 4'b0000};

   st_t               st;
   instr_t            cur;
   instr_t            dec;
   logic [BYTE_W-1:0] wbuf;
   logic              commit;
   logic              wr_tap;
   logic              wr_slot;
   logic [BYTE_W-1:0] rdata;
   logic              addr_hit;

   dpc_decode #(.NPOT(NPOT), .NSLOT(NSLOT)) u_dec (
      .ins (rx_data),
      .dec (dec)
   );

   assign addr_hit = rx_data == (DEV_ADDR_HI | {4'b0000, addr_pins});
   assign commit   = evt_stop && !evt_start && st == S_WSTOP;
   assign wr_tap   = commit && cur.kind == K_WR_TAP;
   assign wr_slot  = commit && cur.kind == K_WR_SLOT;

   dpc_regs #(.NPOT(NPOT), .NSLOT(NSLOT), .WIPER_RST(WIPER_RST)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_tap   (wr_tap),
      .wr_slot  (wr_slot),
      .sel_pot  (cur.pot),
      .sel_slot (cur.slot),
      .wdata    (wbuf),
      .rd_slot  (cur.kind == K_RD_SLOT),
      .rdata    (rdata),
      .tap_flat (wiper_o)
   );

   assign tx_vld  = st == S_RDATA;
   assign tx_data = rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cur     <= '{kind: K_BAD, pot: 2'b00, slot: 2'b00};
         wbuf    <= '0;
         ack_vld <= 1'b0;
         ack_ok  <= 1'b0;
         nv_req  <= 1'b0;
         nv_pot  <= '0;
         nv_slot <= '0;
         nv_data <= '0;
      end else begin
         ack_vld <= 1'b0;
         ack_ok  <= 1'b0;
         nv_req  <= 1'b0;
         if (evt_start) begin
            st <= S_ADDR;
         end else if (evt_stop) begin
            st <= S_IDLE;
            if (wr_slot) begin
               nv_req  <= 1'b1;
               nv_pot  <= cur.pot;
               nv_slot <= cur.slot;
               nv_data <= wbuf;
            end
         end else if (rx_vld) begin
            unique case (st)
               S_ADDR: begin
                  ack_vld <= 1'b1;
                  ack_ok  <= addr_hit;
                  st      <= addr_hit ? S_INSTR : S_IDLE;
               end
               S_INSTR: begin
                  ack_vld <= 1'b1;
                  cur     <= dec;
                  if (dec.kind == K_BAD) begin
                     st <= S_IDLE;
                  end else begin
                     ack_ok <= 1'b1;
                     st     <= (dec.kind == K_RD_TAP || dec.kind == K_RD_SLOT)
                               ? S_RDATA : S_WDATA;
                  end
               end
               S_WDATA: begin
                  ack_vld <= 1'b1;
                  ack_ok  <= 1'b1;
                  wbuf    <= rx_data;
                  st      <= S_WSTOP;
               end
               S_WSTOP: begin
                  ack_vld <= 1'b1;
                  st      <= S_IDLE;
               end
               default: ;
            endcase
         end else if (mack_vld && st == S_RDATA) begin
            st <= mack_nack ? S_RSTOP : S_IDLE;
         end
      end
   end
endmodule

// File: rtl/dpc_cmd_engine_chk.sv
module dpc_cmd_engine_chk #(
   parameter int NPOT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evt_stop,
   input logic             rx_vld,
   input logic             mack_vld,
   input logic             ack_vld,
   input logic             tx_vld,
   input logic             nv_req,
   input logic [NPOT*8-1:0] wiper_o
);
   a_r1_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> $past(rx_vld));

   a_r4_tap_moves_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_o) |-> $past(evt_stop));

   a_r6_nvreq_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      nv_req |-> $past(evt_stop));

   a_r6_nvreq_single: assert property (@(posedge clk) disable iff (!rst_n)
      nv_req |=> !nv_req);

   a_r8_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_vld && mack_vld && !rx_vld) |=> !tx_vld);
endmodule

bind dpc_cmd_engine dpc_cmd_engine_chk #(.NPOT(NPOT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_stop (evt_stop),
   .rx_vld   (rx_vld),
   .mack_vld (mack_vld),
   .ack_vld  (ack_vld),
   .tx_vld   (tx_vld),
   .nv_req   (nv_req),
   .wiper_o  (wiper_o)
);

// File: tb/dpc_cmd_engine_bench.sv
module dpc_cmd_engine_bench;
   localparam int NPOT = 4;
   localparam logic [3:0] PINS = 4'b1011;
   localparam logic [7:0] DEV  = {4'b0101, PINS};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] addr_pins = PINS;
   logic evt_start = 0, evt_stop = 0, rx_vld = 0, mack_vld = 0, mack_nack = 0;
   logic [7:0] rx_data = '0;
   logic ack_vld, ack_ok, tx_vld, nv_req;
   logic [7:0] tx_data, nv_data;
   logic [1:0] nv_pot, nv_slot;
   logic [NPOT*8-1:0] wiper_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   logic [7:0] exp_tap [NPOT];
   logic [7:0] exp_img [NPOT][4];

   always #4 clk = ~clk;

   dpc_cmd_engine u_dpc_cmd_engine (
      .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins),
      .evt_start(evt_start), .evt_stop(evt_stop),
      .rx_vld(rx_vld), .rx_data(rx_data),
      .ack_vld(ack_vld), .ack_ok(ack_ok),
      .tx_vld(tx_vld), .tx_data(tx_data),
      .mack_vld(mack_vld), .mack_nack(mack_nack),
      .wiper_o(wiper_o),
      .nv_req(nv_req), .nv_pot(nv_pot), .nv_slot(nv_slot), .nv_data(nv_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_taps(input string req);
      for (int p = 0; p < NPOT; p++)
         check(req, 32'(wiper_o[p*8 +: 8]), 32'(exp_tap[p]));
   endtask

   task automatic do_start();
      @(negedge clk) evt_start = 1;
      @(negedge clk) evt_start = 0;
   endtask

   task automatic do_stop();
      @(negedge clk) evt_stop = 1;
      @(negedge clk) evt_stop = 0;
   endtask

   task automatic do_byte(input logic [7:0] b, output logic av, output logic ao);
      @(negedge clk) begin rx_vld = 1; rx_data = b; end
      @(negedge clk) rx_vld = 0;
      av = ack_vld;
      ao = ack_ok;
   endtask

   task automatic do_mack(input logic nack);
      @(negedge clk) begin mack_vld = 1; mack_nack = nack; end
      @(negedge clk) mack_vld = 0;
   endtask

   task automatic t_reset();
      check("R10 tx_vld", 32'(tx_vld), 0);
      check("R10 nv_req", 32'(nv_req), 0);
      check("R10 ack_vld", 32'(ack_vld), 0);
      check_taps("R10 tap reset");
   endtask

   task automatic t_write_tap(input int p, input logic [7:0] v);
      logic av, ao;
      do_start();
      do_byte(DEV, av, ao);
      check("R1 addr ack", 32'({av, ao}), 32'b11);
      do_byte({4'b1010, 2'b00, 2'(p)}, av, ao);
      check("R3 instr ack", 32'({av, ao}), 32'b11);
      do_byte(v, av, ao);
      check("R4 data ack", 32'({av, ao}), 32'b11);
      check_taps("R4 before stop");
      do_stop();
      exp_tap[p] = v;
      check_taps("R4 tap written");
      check("R4 no nv_req", 32'(nv_req), 0);
   endtask

   task automatic t_read_tap(input int p, input logic nack);
      logic av, ao;
      do_start();
      do_byte(DEV, av, ao);
      do_byte({4'b1001, 2'b00, 2'(p)}, av, ao);
      check("R5 instr ack", 32'({av, ao}), 32'b11);
      check("R5 tx_vld", 32'(tx_vld), 1);
      check("R5 tx_data", 32'(tx_data), 32'(exp_tap[p]));
      do_mack(nack);
      check("R8 tx released", 32'(tx_vld), 0);
      do_stop();
   endtask

   task automatic t_write_slot(input int p, input int s, input logic [7:0] v);
      logic av, ao;
      do_start();
      do_byte(DEV, av, ao);
      do_byte({4'b1100, 2'(s), 2'(p)}, av, ao);
      check("R6 instr ack", 32'({av, ao}), 32'b11);
      do_byte(v, av, ao);
      do_stop();
      check("R6 nv_req", 32'(nv_req), 1);
      check("R6 nv fields", 32'({nv_pot, nv_slot, nv_data}), 32'({2'(p), 2'(s), v}));
      check_taps("R6 taps unchanged");
      exp_img[p][s] = v;
      @(negedge clk);
      check("R6 nv_req pulse", 32'(nv_req), 0);
   endtask

   task automatic t_read_slot(input int p, input int s);
      logic av, ao;
      do_start();
      do_byte(DEV, av, ao);
      do_byte({4'b1011, 2'(s), 2'(p)}, av, ao);
      check("R7 tx_vld", 32'(tx_vld), 1);
      check("R7 tx_data", 32'(tx_data), 32'(exp_img[p][s]));
      do_mack(1'b1);
      check("R8 tx released", 32'(tx_vld), 0);
      do_stop();
   endtask

   task automatic t_bad_addr();
      logic av, ao;
      do_start();
      do_byte(DEV ^ 8'h01, av, ao);
      check("R2 addr nack", 32'({av, ao}), 32'b10);
      do_byte(8'hA1, av, ao);
      check("R2 ignored instr", 32'(av), 0);
      do_byte(8'h11, av, ao);
      check("R2 ignored data", 32'(av), 0);
      do_stop();
      check_taps("R2 no change");
   endtask

   task automatic t_bad_op(input logic [7:0] ins);
      logic av, ao;
      do_start();
      do_byte(DEV, av, ao);
      do_byte(ins, av, ao);
      check("R3 bad opcode nack", 32'({av, ao}), 32'b10);
      do_byte(8'h22, av, ao);
      check("R3 ignored data", 32'(av), 0);
      do_stop();
      check("R3 no nv_req", 32'(nv_req), 0);
      check_taps("R3 no change");
   endtask

   task automatic t_restart_abort();
      logic av, ao;
      do_start();
      do_byte(DEV, av, ao);
      do_byte(8'hA2, av, ao);
      do_byte(8'h33, av, ao);
      do_start();
      do_stop();
      check_taps("R9 restart cancels");
      check("R9 no nv_req", 32'(nv_req), 0);
   endtask

   task automatic t_extra_byte();
      logic av, ao;
      do_start();
      do_byte(DEV, av, ao);
      do_byte(8'hA3, av, ao);
      do_byte(8'h44, av, ao);
      do_byte(8'h55, av, ao);
      check("R11 extra byte nack", 32'({av, ao}), 32'b10);
      do_stop();
      check_taps("R11 write dropped");
   endtask

   task automatic t_early_stop();
      logic av, ao;
      do_start();
      do_byte(DEV, av, ao);
      do_byte(8'hC5, av, ao);
      do_stop();
      check("R12 no nv_req", 32'(nv_req), 0);
      check_taps("R12 no change");
      t_read_slot(1, 1);
   endtask

   initial begin
      for (int p = 0; p < NPOT; p++) begin
         exp_tap[p] = 8'h80;
         for (int s = 0; s < 4; s++) exp_img[p][s] = 8'h00;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_write_tap(2, 8'h3C);
      t_write_tap(0, 8'hFF);
      t_write_tap(3, 8'h00);
      t_read_tap(2, 1'b1);
      t_read_tap(0, 1'b0);
      t_write_slot(1, 3, 8'hA5);
      t_write_slot(3, 0, 8'h5A);
      t_read_slot(1, 3);
      t_read_slot(3, 0);
      t_read_slot(2, 2);
      t_bad_addr();
      t_bad_op(8'hF0);
      t_bad_op(8'hA4);
      t_bad_op(8'h98);
      t_restart_abort();
      t_extra_byte();
      t_early_stop();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule